// File: doc/BRIEF.md
# Stop-Mode Wake Sequencer

This block decides when a processor clock domain may resume after a low-power stop. While the domain runs, a stop request parks it. Parking drops the core-run enable and turns off the output enable for the external bus pins, so the data lines, strobes and attribute lines float. A low level on the active-low wake interrupt line starts recovery. At that moment the sequencer captures two settings: whether the PLL was kept running through stop, and whether the long stop delay is disabled. These settings choose one of three recovery paths.

With the PLL kept alive, a short fixed count is the only wait. With the PLL shut down and the long delay enabled, a long down-count and the wait for PLL lock run side by side, and recovery ends when the later one finishes. With the PLL shut down and the long delay disabled, the block first waits for lock and then runs a fixed settling count. When the run enable returns, a one-cycle service request is raised, but only if the wake line stayed low for the whole recovery. This models a level-sensitive interrupt that is still pending. A status output shows whether the domain is running, stopped or recovering. The long count is a parameter, so a short value can stand in for 128K cycles in simulation.

Top module: `stop_wake_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, status reads RUN (code 0), the run enable is 1, the bus output enable is 1 and the service request is 0.
- R2: A stop request sampled while running moves status to STOP (code 1) on the next clock edge. Run enable and bus output enable are then 0, and they stay 0 throughout STOP and RECOVER.
- R3: In STOP, a high wake line keeps the block in STOP. A low wake line sampled at an edge moves status to RECOVER (code 2) at that edge.
- R4: Keep-PLL mode (pll_keep=1): taking the wake edge as edge 0, run enable returns after edge FAST_DLY+1, and the PLL lock input is ignored.
- R5: Long mode (pll_keep=0, long_dly_dis=0): if lock is first sampled high at edge k after the wake edge (k≥1), run enable returns after edge max(LONG_DLY+1, k).
- R6: Lock-then-settle mode (pll_keep=0, long_dly_dis=1): if lock is first sampled high at edge k (k≥1), run enable returns after edge k+SHORT_DLY.
- R7: If the wake line is low at every edge of recovery, including the edge that ends it, the service request is 1 for exactly the first cycle back in RUN.
- R8: If the wake line is high at any edge during recovery, no service request is raised when recovery ends.
- R9: Asserting reset during recovery aborts it at once, returning status RUN, run enable 1, bus output enable 1 and service request 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the controlled domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Request to enter stop, sampled while running |
| wake_n | input | 1 | Active-low wake interrupt line |
| pll_keep | input | 1 | 1 keeps the PLL running through stop |
| long_dly_dis | input | 1 | 1 skips the long stop delay |
| pll_locked | input | 1 | PLL lock indication |
| run_en | output | 1 | Core may fetch and execute |
| irq_req | output | 1 | One-cycle interrupt service request after recovery |
| bus_oe | output | 1 | 1 drives external bus pins, 0 tri-states them |
| state_o | output | 2 | 0 running, 1 stopped, 2 recovering |

## Verification
Recovery latency is measured in each mode, with lock arriving at different points. In long mode, lock arrives both before and after the long count expires, which shows whether the exit waits for the later of the two events. In lock-then-settle mode, lock arrives at the first edge and again late, which shows that the settling count starts only after lock. Keep-PLL mode runs with lock held low, which shows that lock is ignored there. The wake line is either held through recovery or released part-way, which separates a serviced wake from a dropped one. A reset during recovery checks the abort.

// File: rtl/stop_wake_seq.sv
module stop_wake_seq #(
  parameter int LONG_DLY  = 131072,
  parameter int SHORT_DLY = 24,
  parameter int FAST_DLY  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       wake_n,
  input  logic       pll_keep,
  input  logic       long_dly_dis,
  input  logic       pll_locked,
  output logic       run_en,
  output logic       irq_req,
  output logic       bus_oe,
  output logic [1:0] state_o
);

  localparam int CW = $clog2(LONG_DLY + 1);

  typedef enum logic [1:0] {S_RUN = 2'd0, S_STOP = 2'd1, S_REC = 2'd2} st_t;
  typedef enum logic [1:0] {M_FAST = 2'd0, M_LONG = 2'd1, M_SETTLE = 2'd2} md_t;

  st_t          state;
  md_t          mode;
  logic [CW-1:0] cnt;
  logic         lock_seen;
  logic         wake_ok;
  logic         irq_q;

  wire lock_ok  = (mode == M_FAST) | lock_seen | pll_locked;
  wire cnt_zero = (cnt == '0);
  wire dec_en   = (mode != M_SETTLE) | lock_ok;
  wire rec_done = cnt_zero & lock_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_RUN;
      mode      <= M_FAST;
      cnt       <= '0;
      lock_seen <= 1'b0;
      wake_ok   <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (state)
        S_RUN: if (stop_req) state <= S_STOP;
        S_STOP: if (!wake_n) begin
          state     <= S_REC;
          wake_ok   <= 1'b1;
          lock_seen <= 1'b0;
          if (pll_keep) begin
            mode <= M_FAST;
            cnt  <= CW'(FAST_DLY);
          end else if (!long_dly_dis) begin
            mode <= M_LONG;
            cnt  <= CW'(LONG_DLY);
          end else begin
            mode <= M_SETTLE;
            cnt  <= CW'(SHORT_DLY);
          end
        end
        S_REC: begin
          if (pll_locked) lock_seen <= 1'b1;
          if (wake_n) wake_ok <= 1'b0;
          if (rec_done) begin
            state <= S_RUN;
            irq_q <= wake_ok & ~wake_n;
          end else if (dec_en && !cnt_zero) begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_RUN;
      endcase
    end
  end

  assign run_en  = (state == S_RUN);
  assign bus_oe  = run_en;
  assign irq_req = irq_q;
  assign state_o = state;

  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && stop_req) |=> (state_o == 2'd1 && !bus_oe)); // R2
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && wake_n) |=> (state_o == 2'd1)); // R3
  AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && !wake_n) |=> (state_o == 2'd2)); // R3
  AST_NO_EARLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && !cnt_zero) |=> !run_en); // R5
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req); // R7
  AST_IRQ_AFTER_REC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> (run_en && $past(state_o) == 2'd2)); // R7
  AST_DROP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && wake_n) |=> !irq_req); // R8

endmodule

// File: tb/stop_wake_seq_tb.sv
module stop_wake_seq_tb;
  localparam int CLK_P = 10;
  localparam int LD = 40;
  localparam int SD = 24;
  localparam int FD = 8;

  logic clk = 0, rst_n = 0, stop_req = 0, wake_n = 1;
  logic pll_keep = 0, long_dly_dis = 0, pll_locked = 0;
  logic run_en, irq_req, bus_oe;
  logic [1:0] state_o;

  int compared = 0, mismatched = 0;
  int q_lat[$];
  bit q_irq[$];
  string q_req[$];
  bit finished = 0;

  stop_wake_seq #(.LONG_DLY(LD), .SHORT_DLY(SD), .FAST_DLY(FD)) u_dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_n(wake_n),
    .pll_keep(pll_keep), .long_dly_dis(long_dly_dis), .pll_locked(pll_locked),
    .run_en(run_en), .irq_req(irq_req), .bus_oe(bus_oe), .state_o(state_o));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_latency(input bit keep, input bit ldis, input int k);
    if (keep) return FD + 1;
    if (!ldis) return (k > LD + 1) ? k : LD + 1;
    return k + SD;
  endfunction

  bit trk = 0;
  int n = 0;
  always @(negedge clk) begin
    if (!rst_n) trk = 0;
    else if (!trk && state_o == 2'd2) begin trk = 1; n = 0; end
    else if (trk) begin
      n++;
      if (run_en) begin
        trk = 0;
        if (q_lat.size() > 0) begin
          int el; bit ei; string rq;
          el = q_lat.pop_front(); ei = q_irq.pop_front(); rq = q_req.pop_front();
          check(n == el, rq, "recovery latency", n, el);
          check(irq_req == ei, ei ? "R7" : "R8", "service request", irq_req, ei);
          check(bus_oe == 1, "R2", "bus enable after recovery", bus_oe, 1);
        end
      end
    end
  end

  task automatic enter_stop();
    stop_req = 1;
    @(negedge clk);
    stop_req = 0;
    check(state_o == 2'd1, "R2", "status after stop", state_o, 1);
    check(run_en == 0 && bus_oe == 0, "R2", "run/bus off in stop", {run_en, bus_oe}, 0);
  endtask

  task automatic recover(input bit keep, input bit ldis, input int k, input int rel_at, input string req);
    pll_keep = keep; long_dly_dis = ldis; pll_locked = 0;
    enter_stop();
    wake_n = 0;
    if (k == 0 && !keep) pll_locked = 1;
    q_lat.push_back(exp_latency(keep, ldis, (k == 0) ? 1 : k));
    q_irq.push_back(rel_at == 0);
    q_req.push_back(req);
    @(negedge clk);
    check(state_o == 2'd2, "R3", "status recovering", state_o, 2);
    for (int i = 1; i < 500; i++) begin
      if (k > 0 && i == k) pll_locked = 1;
      if (rel_at > 0 && i == rel_at) wake_n = 1;
      @(negedge clk);
      if (run_en) break;
      if (bus_oe) check(0, "R2", "bus enable during recovery", bus_oe, 0);
    end
    wake_n = 1; pll_locked = 0;
    @(negedge clk);
    check(irq_req == 0, "R7", "request lasts one cycle", irq_req, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 2 + 1);
    check(state_o == 0 && run_en && bus_oe && !irq_req, "R1", "reset outputs", state_o, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check(state_o == 0 && run_en && bus_oe && !irq_req, "R1", "after reset", state_o, 0);

    pll_keep = 1;
    enter_stop();
    repeat (5) @(negedge clk);
    check(state_o == 2'd1, "R3", "stays stopped with wake high", state_o, 1);
    wake_n = 0; q_lat.push_back(FD + 1); q_irq.push_back(1); q_req.push_back("R4");
    while (!run_en) @(negedge clk);
    wake_n = 1; @(negedge clk);

    recover(1, 0, 0, 0, "R4");
    recover(0, 0, 10, 0, "R5");
    recover(0, 0, 60, 0, "R5");
    recover(0, 0, 0, 0, "R5");
    recover(0, 1, 5, 0, "R6");
    recover(0, 1, 1, 0, "R6");
    recover(0, 1, 12, 0, "R6");
    recover(1, 0, 0, 4, "R8");
    recover(0, 1, 3, 2, "R8");

    pll_keep = 0; long_dly_dis = 0;
    enter_stop();
    wake_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 0; #1;
    check(state_o == 0 && run_en && bus_oe && !irq_req, "R9", "abort on reset", state_o, 0);
    @(negedge clk); rst_n = 1; wake_n = 1;
    repeat (3) @(negedge clk);
    check(state_o == 0 && run_en, "R9", "running after abort", state_o, 0);
    check(q_lat.size() == 0, "R4", "all recoveries observed", q_lat.size(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule